// File: doc/BRIEF.md
# E1 Continuous Remote-Block-Error Alarm Monitor

This block watches the E bits carried in the CRC-4 multiframe of a received E1 line and raises an alarm when the far end reports block errors almost without a break. For each E bit already pulled out of the frame it takes a valid strobe and the bit value. It also takes a one-second tick, a frame-alignment-lost flag and a multiframe-aligned flag. It counts the zero E bits in each second. It then tracks how many back-to-back seconds reached the threshold, and the alarm is asserted once five such seconds have been seen in a row.

The run is restarted by alignment events. Two qualifiers can also restart it, each with its own enable: the received A bit (remote alarm) and the decoded Sa6 "1111" and "1110" code indications. While any restart cause is present the run cannot start. The run begins at the first one-second tick after every restart cause has cleared, so only whole seconds are counted. The alarm is forced low whenever frame alignment or multiframe alignment is missing.

Top module: `ebit_alarm_mon`

## Requirements
- R1: After the arming tick, the alarm output goes high one clock after the fifth consecutive tick that closes a second with at least 991 zero E bits. A zero E bit is an `ebit_vld` cycle with `ebit_val` = 0. A second is the set of cycles between two `sec_tick` pulses.
- R2: A tick that closes a second with 990 or fewer zero E bits sets `sec_cnt` to 0 one clock later and deasserts the alarm.
- R3: `frame_lost` high in any cycle sets `sec_cnt` to 0 on the next clock. The next tick after it clears then only arms the run.
- R4: While `mf_aligned` is low, `sec_cnt` stays 0. The first tick after it is high, with no other restart cause present, arms the run. `sec_cnt` then counts the seconds closed by later ticks.
- R5: With `abit_qual_en` = 1, `abit_val` = 1 restarts the run, and the run is not armed while it is held. With `abit_qual_en` = 0, the A bit has no effect.
- R6: With `sa6_qual_en` = 1, `sa6_f_code` or `sa6_e_code` restarts the run, and the run is not armed while either is held. With `sa6_qual_en` = 0, these codes have no effect.
- R7: The alarm is low in the same cycle as `frame_lost` = 1 or `mf_aligned` = 0.
- R8: E bits with value 1 do not add to the per-second count.
- R9: The per-second zero count saturates rather than wraps. A second with 2100 zero E bits passes.
- R10: `sec_cnt` saturates at 5 while further passing seconds arrive, and the alarm stays high.
- R11: After reset, `alarm` = 0 and `sec_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ebit_vld | input | 1 | One received E bit is present this cycle |
| ebit_val | input | 1 | Value of that E bit |
| sec_tick | input | 1 | One-cycle pulse that closes each second |
| frame_lost | input | 1 | Basic frame alignment is lost |
| mf_aligned | input | 1 | CRC-4 multiframe alignment is held |
| abit_qual_en | input | 1 | Enable the A-bit qualifier |
| abit_val | input | 1 | Received A bit (remote alarm) |
| sa6_qual_en | input | 1 | Enable the Sa6 code qualifier |
| sa6_f_code | input | 1 | Sa6 pattern 1111 detected |
| sa6_e_code | input | 1 | Sa6 pattern 1110 detected |
| alarm | output | 1 | Continuous E-bit alarm |
| sec_cnt | output | 3 | Consecutive passing seconds, saturating at 5 |

## Verification
The per-second count is tried at 990 and 991 zeros, which separates a correct threshold from an off-by-one compare. It is also tried with many one-valued E bits mixed among the zeros, which shows whether ones are wrongly counted, and with 2100 zeros, which shows whether the counter wraps or saturates. Restart causes are applied as short pulses in the middle of a run and as levels held across a tick. The pulses test clearing, and the held levels test the arming rule. Each qualifier is applied once with its enable off and once with it on, so a qualifier that is ignored can be told apart from one that is always active.

// File: rtl/ebit_alarm_pkg.sv
package ebit_alarm_pkg;
  // a second passes when its zero count reaches the threshold
  function automatic bit sec_meets(input int unsigned zeros, input int unsigned thresh);
    return zeros >= thresh;
  endfunction

  // saturating increment against a ceiling
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned ceil);
    return (cur >= ceil) ? ceil : cur + 1;
  endfunction
endpackage

// File: rtl/ebit_zero_ctr.sv
module ebit_zero_ctr
  import ebit_alarm_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int THRESH = 991
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_ev,
  input  logic             sec_tick,
  output logic [CNT_W-1:0] zcnt,
  output logic             sec_good
);
  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sec_tick) begin
      // an event on the tick cycle opens the new second
      cnt_q <= zero_ev ? CNT_W'(1) : '0;
    end else if (zero_ev) begin
      cnt_q <= CNT_W'(sat_next(int'(cnt_q), CMAX));
    end
  end

  assign zcnt     = cnt_q;
  assign sec_good = sec_meets(int'(cnt_q), THRESH);
endmodule

// File: rtl/ebit_run_seq.sv
module ebit_run_seq
  import ebit_alarm_pkg::*;
#(
  parameter int RUN_SECS = 5,
  parameter int SEC_W    = $clog2(RUN_SECS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             sec_good,
  input  logic             restart,
  output logic             running,
  output logic [SEC_W-1:0] secs
);
  logic             run_q;
  logic [SEC_W-1:0] secs_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      run_q  <= 1'b0;
      secs_q <= '0;
    end else if (sec_tick) begin
      if (!run_q) begin
        run_q <= 1'b1;   // arm at a second boundary
      end else if (sec_good) begin
        secs_q <= SEC_W'(sat_next(int'(secs_q), RUN_SECS));
      end else begin
        secs_q <= '0;
      end
    end
  end

  assign running = run_q;
  assign secs    = secs_q;
endmodule

// File: rtl/ebit_alarm_mon.sv
module ebit_alarm_mon #(
  parameter int CNT_W    = 11,
  parameter int THRESH   = 991,
  parameter int RUN_SECS = 5,
  localparam int SEC_W   = $clog2(RUN_SECS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ebit_vld,
  input  logic             ebit_val,
  input  logic             sec_tick,
  input  logic             frame_lost,
  input  logic             mf_aligned,
  input  logic             abit_qual_en,
  input  logic             abit_val,
  input  logic             sa6_qual_en,
  input  logic             sa6_f_code,
  input  logic             sa6_e_code,
  output logic             alarm,
  output logic [SEC_W-1:0] sec_cnt
);
  logic             zero_ev_w;
  logic             sec_good_w;
  logic             restart_w;
  logic             running_w;
  logic             align_ok_w;
  logic [CNT_W-1:0] zcnt_w;
  logic [SEC_W-1:0] secs_w;

  assign zero_ev_w  = ebit_vld && !ebit_val;
  assign align_ok_w = mf_aligned && !frame_lost;
  assign restart_w  = !align_ok_w
                   || (abit_qual_en && abit_val)
                   || (sa6_qual_en && (sa6_f_code || sa6_e_code));

  ebit_zero_ctr #(.CNT_W(CNT_W), .THRESH(THRESH)) u_zero (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_ev  (zero_ev_w),
    .sec_tick (sec_tick),
    .zcnt     (zcnt_w),
    .sec_good (sec_good_w)
  );

  ebit_run_seq #(.RUN_SECS(RUN_SECS), .SEC_W(SEC_W)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .sec_good (sec_good_w),
    .restart  (restart_w),
    .running  (running_w),
    .secs     (secs_w)
  );

  assign sec_cnt = secs_w;
  assign alarm   = running_w && (secs_w == SEC_W'(RUN_SECS)) && align_ok_w;
endmodule

// File: rtl/ebit_alarm_chk.sv
module ebit_alarm_chk #(
  parameter int RUN_SECS = 5,
  parameter int SEC_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             frame_lost,
  input logic             mf_aligned,
  input logic             abit_qual_en,
  input logic             abit_val,
  input logic             sa6_qual_en,
  input logic             sa6_f_code,
  input logic             sa6_e_code,
  input logic             sec_good_w,
  input logic             alarm,
  input logic [SEC_W-1:0] sec_cnt
);
  // R1: a rising alarm follows a passing tick
  a_r1_rise_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> ($past(sec_tick) && $past(sec_good_w)));

  // R2: a failing second clears the run
  a_r2_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !sec_good_w) |=> (sec_cnt == '0));

  // R3: loss of frame alignment clears the run
  a_r3_lfa_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |=> (sec_cnt == '0));

  // R4: no run without multiframe alignment
  a_r4_needs_mfa: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_aligned |=> (sec_cnt == '0));

  // R5: enabled A bit restarts
  a_r5_abit_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (abit_qual_en && abit_val) |=> (sec_cnt == '0 && !alarm));

  // R6: enabled Sa6 code restarts
  a_r6_sa6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sa6_qual_en && (sa6_f_code || sa6_e_code)) |=> (sec_cnt == '0 && !alarm));

  // R7: alarm gated by alignment
  a_r7_align_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_lost || !mf_aligned) |-> !alarm);

  // R10: run count never exceeds its ceiling
  a_r10_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    sec_cnt <= SEC_W'(RUN_SECS));
endmodule

bind ebit_alarm_mon ebit_alarm_chk #(.RUN_SECS(RUN_SECS), .SEC_W(SEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_tick     (sec_tick),
  .frame_lost   (frame_lost),
  .mf_aligned   (mf_aligned),
  .abit_qual_en (abit_qual_en),
  .abit_val     (abit_val),
  .sa6_qual_en  (sa6_qual_en),
  .sa6_f_code   (sa6_f_code),
  .sa6_e_code   (sa6_e_code),
  .sec_good_w   (sec_good_w),
  .alarm        (alarm),
  .sec_cnt      (sec_cnt)
);

// File: tb/sim_ebit_alarm_mon.sv
`timescale 1ns/1ps
module sim_ebit_alarm_mon;
  localparam int THR = 991;
  localparam int RUNS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ebit_vld = 0, ebit_val = 0, sec_tick = 0;
  logic frame_lost = 0, mf_aligned = 0;
  logic abit_qual_en = 0, abit_val = 0;
  logic sa6_qual_en = 0, sa6_f_code = 0, sa6_e_code = 0;
  logic alarm;
  logic [2:0] sec_cnt;

  int n_run = 0, n_fail = 0;
  bit exp_run = 0;
  int exp_secs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ebit_alarm_mon u0 (
    .clk(clk), .rst_n(rst_n), .ebit_vld(ebit_vld), .ebit_val(ebit_val),
    .sec_tick(sec_tick), .frame_lost(frame_lost), .mf_aligned(mf_aligned),
    .abit_qual_en(abit_qual_en), .abit_val(abit_val),
    .sa6_qual_en(sa6_qual_en), .sa6_f_code(sa6_f_code), .sa6_e_code(sa6_e_code),
    .alarm(alarm), .sec_cnt(sec_cnt));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit blocked();
    return !mf_aligned || frame_lost || (abit_qual_en && abit_val)
        || (sa6_qual_en && (sa6_f_code || sa6_e_code));
  endfunction

  function automatic int exp_alarm();
    return (exp_secs == RUNS && mf_aligned && !frame_lost) ? 1 : 0;
  endfunction

  // one second: nz zero E bits, then no one-valued bits, then the tick
  task automatic second(input int nz, input int no);
    for (int i = 0; i < nz; i++) begin
      @(negedge clk); ebit_vld = 1; ebit_val = 0;
    end
    for (int i = 0; i < no; i++) begin
      @(negedge clk); ebit_vld = 1; ebit_val = 1;
    end
    @(negedge clk); ebit_vld = 0; ebit_val = 0; sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    if (blocked()) begin
      exp_run = 0; exp_secs = 0;
    end else if (!exp_run) begin
      exp_run = 1;
    end else if (nz >= THR) begin
      exp_secs = (exp_secs >= RUNS) ? RUNS : exp_secs + 1;
    end else begin
      exp_secs = 0;
    end
  endtask

  task automatic restart_model();
    exp_run = 0; exp_secs = 0;
  endtask

  task automatic reach_alarm();
    second(10, 0);
    for (int s = 0; s < RUNS; s++) second(THR, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset alarm", alarm, 0);
    check("R11 reset sec_cnt", sec_cnt, 0);

    // R4: no multiframe alignment, passing seconds do not count
    second(THR, 0); second(THR, 0);
    check("R4 no mfa sec_cnt", sec_cnt, 0);
    mf_aligned = 1;
    second(THR, 0);
    check("R4 arming tick sec_cnt", sec_cnt, exp_secs);
    for (int s = 0; s < RUNS - 1; s++) second(THR, 0);
    check("R1 four seconds sec_cnt", sec_cnt, 4);
    check("R1 four seconds alarm", alarm, 0);
    second(THR, 0);
    check("R1 fifth second alarm", alarm, 1);
    check("R1 fifth second sec_cnt", sec_cnt, exp_secs);
    second(THR + 5, 0);
    check("R10 saturate sec_cnt", sec_cnt, 5);
    check("R10 alarm held", alarm, 1);

    // R2: 990 zeros fails
    second(THR - 1, 0);
    check("R2 fail sec_cnt", sec_cnt, 0);
    check("R2 fail alarm", alarm, 0);

    // R8: ones do not count
    second(THR - 1, 300);
    check("R8 ones ignored sec_cnt", sec_cnt, exp_secs);
    second(THR, 200);
    check("R8 mixed pass sec_cnt", sec_cnt, exp_secs);
    check("R8 mixed pass value", sec_cnt, 1);

    // R9: saturation of the zero count
    second(2100, 0);
    check("R9 big second sec_cnt", sec_cnt, 2);

    // R3, R7: loss of frame alignment at alarm
    restart_model(); frame_lost = 1; @(negedge clk); frame_lost = 0;
    reach_alarm();
    check("R1 alarm before lfa", alarm, 1);
    @(negedge clk); frame_lost = 1; #1;
    check("R7 lfa same cycle alarm", alarm, 0);
    @(negedge clk); frame_lost = 0;
    restart_model();
    check("R3 lfa sec_cnt", sec_cnt, 0);
    second(THR, 0);
    check("R3 re-arm sec_cnt", sec_cnt, 0);
    second(THR, 0);
    check("R3 count after re-arm", sec_cnt, 1);

    // R7: mfa drop at alarm
    for (int s = 0; s < RUNS - 1; s++) second(THR, 0);
    check("R1 alarm again", alarm, 1);
    @(negedge clk); mf_aligned = 0; #1;
    check("R7 mfa drop alarm", alarm, 0);
    @(negedge clk); mf_aligned = 1; restart_model();
    check("R4 mfa drop sec_cnt", sec_cnt, 0);

    // R5: A bit disabled has no effect, enabled restarts and blocks
    second(THR, 0); second(THR, 0);
    abit_val = 1; second(THR, 0);
    check("R5 disabled A no effect", sec_cnt, 2);
    @(negedge clk); abit_qual_en = 1; @(negedge clk); abit_val = 0; restart_model();
    check("R5 A pulse sec_cnt", sec_cnt, 0);
    abit_val = 1; second(THR, 0); second(THR, 0);
    check("R5 A held no arm", sec_cnt, 0);
    abit_val = 0; second(THR, 0); second(THR, 0);
    check("R5 after A clears", sec_cnt, 1);
    abit_qual_en = 0;

    // R6: Sa6 codes
    sa6_f_code = 1; second(THR, 0);
    check("R6 disabled Sa6 no effect", sec_cnt, 2);
    sa6_f_code = 0;
    @(negedge clk); sa6_qual_en = 1; sa6_e_code = 1; @(negedge clk); sa6_e_code = 0;
    restart_model();
    check("R6 Sa6 E pulse sec_cnt", sec_cnt, 0);
    sa6_f_code = 1; second(THR, 0); second(THR, 0);
    check("R6 Sa6 F held no arm", sec_cnt, 0);
    sa6_f_code = 0; reach_alarm();
    check("R1 alarm after Sa6 clears", alarm, exp_alarm());
    check("R1 alarm final value", alarm, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule